// File: doc/BRIEF.md
# Four-Operator Connection Router

This block works out, for every operator of a two-bank FM tone generator, whether that operator takes a modulation input and which operator supplies it. Each bank holds nine channels. Each channel owns two operators and one algorithm bit. In the base mode every channel is an independent two-operator voice. In the extended mode a six-bit pairing register can merge the first three channels of each bank with the three channels that follow them. Each merged pair forms a four-operator chain, and the two algorithm bits of the pair select the chain's topology.

The routing is a pure function of the current algorithm bits, pairing bits and mode flag. It is evaluated combinationally and captured in one output register per operator, so every result appears one clock after the inputs that produced it. Downstream operator logic reads the enable bit and the source index to select its phase-modulation input.

Operator numbering: channel `c` in bank `b` (offset `k = c - 9b`) has first operator `18b + k + 3*floor(k/3)` and second operator that index plus 3. This gives operators 0,1,2 and 3,4,5 for channels 0-2; 6,7,8 and 9,10,11 for channels 3-5; 12,13,14 and 15,16,17 for channels 6-8; and the same plus 18 in bank 1.

Top module: `fm_conn_router`

## Requirements
- R1: While `rst` is high at a rising edge, after that edge every bit of `mod_en` and `mod_src` is 0.
- R2: Outputs change only at a rising edge. They show the routing of the inputs sampled at the previous rising edge, and stay unchanged while the inputs stay unchanged.
- R3: For a channel that is not merged, its first operator has no modulator. Its second operator is fed from its first operator when the channel's algorithm bit is 0, and has no modulator when the bit is 1.
- R4: Pairing bit `i` (i = 0..2) merges channel i (lower) with channel i+3 (upper). Bit `i` (i = 3..5) merges channel i+6 with channel i+9. A merge takes effect only while `ext_mode` is 1. With `ext_mode` 0 the pairing bits have no effect.
- R5: In a merged pair with lower first operator `op`, the chain is op, op+3, op+6, op+9. The selector is {lower algorithm bit, upper algorithm bit}, with the lower bit as MSB. Operator op has no modulator.
- R6: Selector 0: op+3 is fed from op, op+6 from op+3, and op+9 from op+6.
- R7: Selector 1: op+3 is fed from op, op+6 has no modulator, and op+9 is fed from op+6.
- R8: Selector 2: op+3 has no modulator, op+6 is fed from op+3, and op+9 is fed from op+6.
- R9: Selector 3: op+3 has no modulator, op+6 is fed from op+3, and op+9 has no modulator.
- R10: An operator whose `mod_en` bit is 0 reports source index 0. An enabled operator n always reports source n-3.
- R11: Channels 6, 7, 8, 15, 16 and 17 are never merged and always follow R3, whatever the pairing bits and mode are.
- R12: Clearing a pairing bit returns both channels of that pair to independent R3 routing, one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| chan_alg | input | 18 | Algorithm bit per channel, bit c for channel c |
| conn_sel | input | 6 | Pairing bits, bit i merges the pair described in R4 |
| ext_mode | input | 1 | 1 enables four-operator merging |
| mod_en | output | 36 | Bit n is 1 when operator n takes a modulation input |
| mod_src | output | 216 | Six bits per operator; bits [6n+5:6n] give the source operator of operator n |

## Verification
There is no state in this block beyond the output register, so a wrong routing decision shows up at the ports on the very next clock. The affected operator's enable bit or source index differs from the value computed from the inputs. A fault in selector decoding, in the pair-to-channel mapping or in the bank offset shows only for particular combinations of algorithm and pairing bits. For that reason the stimulus covers all four selectors on pairs in both banks, the base mode with every pairing bit set, and long pseudo-random sequences checked against a reference model on every clock.

// File: rtl/fm_route_pkg.sv
package fm_route_pkg;

  localparam int BANK_CH    = 9;
  localparam int BANK_OPS   = 18;
  localparam int BANK_PAIRS = 3;
  localparam int LONE_CH    = BANK_CH - 2 * BANK_PAIRS;
  localparam int CHAIN_LEN  = 4;
  localparam int OP_STRIDE  = 3;

  typedef enum logic [1:0] {
    TOPO_SERIAL  = 2'd0,
    TOPO_MIDCUT  = 2'd1,
    TOPO_HEADCUT = 2'd2,
    TOPO_TWIN    = 2'd3
  } chain_topo_e;

endpackage

// File: rtl/fm_route_quad.sv
module fm_route_quad
  import fm_route_pkg::*;
#(
  parameter int OP_W = 6,
  parameter int BASE = 0
) (
  input  logic                                lo_alg,
  input  logic                                hi_alg,
  input  logic                                merged,
  output logic [CHAIN_LEN-1:0]                en,
  output logic [CHAIN_LEN-1:0][OP_W-1:0]      src
);

  chain_topo_e topo;

  assign topo = chain_topo_e'({lo_alg, hi_alg});

  always_comb begin
    en = '0;
    if (merged) begin
      unique case (topo)
        TOPO_SERIAL:  en = 4'b1110;
        TOPO_MIDCUT:  en = 4'b1010;
        TOPO_HEADCUT: en = 4'b1100;
        TOPO_TWIN:    en = 4'b0100;
        default:      en = '0;
      endcase
    end else begin
      en[1] = ~lo_alg;
      en[3] = ~hi_alg;
    end
  end

  always_comb begin
    src[0] = '0;
    for (int q = 1; q < CHAIN_LEN; q++) begin
      src[q] = en[q] ? OP_W'(BASE + OP_STRIDE * (q - 1)) : '0;
    end
  end

endmodule

// File: rtl/fm_route_duo.sv
module fm_route_duo
  import fm_route_pkg::*;
#(
  parameter int OP_W = 6,
  parameter int BASE = 0
) (
  input  logic                 alg,
  output logic [1:0]           en,
  output logic [1:0][OP_W-1:0] src
);

  assign en[0]  = 1'b0;
  assign en[1]  = ~alg;
  assign src[0] = '0;
  assign src[1] = alg ? '0 : OP_W'(BASE);

endmodule

// File: rtl/fm_route_reg.sv
module fm_route_reg #(
  parameter int N    = 36,
  parameter int OP_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N-1:0]          d_en,
  input  logic [N-1:0][OP_W-1:0] d_src,
  output logic [N-1:0]          q_en,
  output logic [N-1:0][OP_W-1:0] q_src
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_en  <= '0;
      q_src <= '0;
    end else begin
      q_en  <= d_en;
      q_src <= d_src;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R10
    idle_src_chk: assert property (@(posedge clk) disable iff (rst)
      !q_en[i] |-> (q_src[i] == '0));
    if (i >= 3) begin : g_fwd
      // R10
      fwd_src_chk: assert property (@(posedge clk) disable iff (rst)
        q_en[i] |-> (q_src[i] == OP_W'(i - 3)));
    end
  end

endmodule

// File: rtl/fm_conn_router.sv
module fm_conn_router
  import fm_route_pkg::*;
#(
  parameter  int BANKS     = 2,
  localparam int NUM_CH    = BANKS * BANK_CH,
  localparam int NUM_OPS   = BANKS * BANK_OPS,
  localparam int NUM_PAIRS = BANKS * BANK_PAIRS,
  localparam int OP_W      = $clog2(NUM_OPS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH-1:0]       chan_alg,
  input  logic [NUM_PAIRS-1:0]    conn_sel,
  input  logic                    ext_mode,
  output logic [NUM_OPS-1:0]      mod_en,
  output logic [NUM_OPS*OP_W-1:0] mod_src
);

  logic [NUM_OPS-1:0]           nxt_en;
  logic [NUM_OPS-1:0][OP_W-1:0] nxt_src;
  logic [NUM_OPS-1:0][OP_W-1:0] q_src;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    for (genvar p = 0; p < BANK_PAIRS; p++) begin : g_pair
      localparam int BASE = b * BANK_OPS + p;
      localparam int LO   = b * BANK_CH + p;
      localparam int HI   = LO + BANK_PAIRS;
      localparam int PI   = b * BANK_PAIRS + p;

      logic                           merged;
      logic [CHAIN_LEN-1:0]           w_en;
      logic [CHAIN_LEN-1:0][OP_W-1:0] w_src;

      assign merged = ext_mode & conn_sel[PI];

      fm_route_quad #(.OP_W(OP_W), .BASE(BASE)) u_quad (
        .lo_alg (chan_alg[LO]),
        .hi_alg (chan_alg[HI]),
        .merged (merged),
        .en     (w_en),
        .src    (w_src)
      );

      for (genvar q = 0; q < CHAIN_LEN; q++) begin : g_link
        assign nxt_en[BASE + OP_STRIDE * q]  = w_en[q];
        assign nxt_src[BASE + OP_STRIDE * q] = w_src[q];
      end

      // R6
      serial_chain_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_mode && conn_sel[PI] && !chan_alg[LO] && !chan_alg[HI]) |=>
        (mod_en[BASE+3] && mod_en[BASE+6] && mod_en[BASE+9] &&
         mod_src[(BASE+9)*OP_W +: OP_W] == OP_W'(BASE + 6)));

      // R9
      twin_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_mode && conn_sel[PI] && chan_alg[LO] && chan_alg[HI]) |=>
        (!mod_en[BASE+3] && mod_en[BASE+6] && !mod_en[BASE+9]));

      // R4
      ignore_sel_chk: assert property (@(posedge clk) disable iff (rst)
        !ext_mode |=>
        (!mod_en[BASE+6] && (mod_en[BASE+9] == !$past(chan_alg[HI]))));

      // R5
      head_free_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_mode && conn_sel[PI]) |=> !mod_en[BASE]);
    end

    for (genvar k = 0; k < LONE_CH; k++) begin : g_lone
      localparam int BASE = b * BANK_OPS + CHAIN_LEN * BANK_PAIRS + k;
      localparam int CH   = b * BANK_CH + 2 * BANK_PAIRS + k;

      logic [1:0]           w_en;
      logic [1:0][OP_W-1:0] w_src;

      fm_route_duo #(.OP_W(OP_W), .BASE(BASE)) u_duo (
        .alg (chan_alg[CH]),
        .en  (w_en),
        .src (w_src)
      );

      assign nxt_en[BASE]              = w_en[0];
      assign nxt_src[BASE]             = w_src[0];
      assign nxt_en[BASE + OP_STRIDE]  = w_en[1];
      assign nxt_src[BASE + OP_STRIDE] = w_src[1];

      // R11
      lone_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (!mod_en[BASE] && (mod_en[BASE+3] == !$past(chan_alg[CH]))));
    end
  end

  fm_route_reg #(.N(NUM_OPS), .OP_W(OP_W)) u_reg (
    .clk   (clk),
    .rst   (rst),
    .d_en  (nxt_en),
    .d_src (nxt_src),
    .q_en  (mod_en),
    .q_src (q_src)
  );

  assign mod_src = q_src;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (mod_en == '0 && mod_src == '0));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(chan_alg) && $stable(conn_sel) && $stable(ext_mode)) |=>
    ($stable(mod_en) && $stable(mod_src)));

endmodule

// File: tb/tb_fm_conn_router.sv
`timescale 1ns/1ps
module tb_fm_conn_router;

  localparam int NCH  = 18;
  localparam int NPR  = 6;
  localparam int NOPS = 36;
  localparam int OPW  = 6;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] chan_alg = '0;
  logic [NPR-1:0] conn_sel = '0;
  logic ext_mode = 1'b0;
  logic [NOPS-1:0] mod_en;
  logic [NOPS*OPW-1:0] mod_src;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;
  bit started = 0;
  string cur_req = "R1";
  logic [NOPS+NOPS*OPW-1:0] exp_vec;

  always #2.5 clk = ~clk;

  fm_conn_router dut (
    .clk(clk), .rst(rst), .chan_alg(chan_alg), .conn_sel(conn_sel),
    .ext_mode(ext_mode), .mod_en(mod_en), .mod_src(mod_src)
  );

  function automatic logic [NOPS+NOPS*OPW-1:0] model(
      input logic [NCH-1:0] a, input logic [NPR-1:0] s, input logic x);
    logic [NOPS-1:0] e;
    logic [NOPS*OPW-1:0] sv;
    e = '0;
    sv = '0;
    for (int o = 0; o < NOPS; o++) begin
      int bank, r, grp, slot, ch, pos, sel, lo, up;
      bit second, on;
      bank   = o / 18;
      r      = o % 18;
      grp    = r / 6;
      slot   = (r % 6) % 3;
      second = (r % 6) >= 3;
      ch     = bank * 9 + grp * 3 + slot;
      on     = second && !a[ch];
      if (x && grp < 2 && s[bank * 3 + slot]) begin
        lo  = bank * 9 + slot;
        up  = lo + 3;
        sel = {a[lo], a[up]};
        pos = grp * 2 + int'(second);
        case (pos)
          0: on = 0;
          1: on = (sel < 2);
          2: on = (sel != 1);
          default: on = (sel != 3);
        endcase
      end
      e[o] = on;
      if (on) sv[o*OPW +: OPW] = OPW'(o - 3);
    end
    return {e, sv};
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) exp_vec <= '0;
    else     exp_vec <= model(chan_alg, conn_sel, ext_mode);
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if ({mod_en, mod_src} !== exp_vec) begin
        fails++;
        $display("FAIL %s per-clock: actual en=%h src=%h expected en=%h src=%h",
                 cur_req, mod_en, mod_src, exp_vec[NOPS+NOPS*OPW-1 -: NOPS],
                 exp_vec[NOPS*OPW-1:0]);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cyc, LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int op, input logic e, input int s);
    logic [OPW-1:0] got;
    got = mod_src[op*OPW +: OPW];
    checks++;
    if (mod_en[op] !== e || got !== OPW'(s)) begin
      fails++;
      $display("FAIL %s op%0d: actual en=%b src=%0d expected en=%b src=%0d",
               req, op, mod_en[op], got, e, s);
    end
  endtask

  task automatic apply(input logic [NCH-1:0] a, input logic [NPR-1:0] s, input logic x);
    @(negedge clk);
    chan_alg = a;
    conn_sel = s;
    ext_mode = x;
    @(negedge clk);
    #0.5;
  endtask

  initial begin
    logic [31:0] lf;
    logic [NOPS-1:0] held_en;
    logic [NOPS*OPW-1:0] held_src;
    // R1: reset clears all outputs
    chan_alg = '1;
    repeat (3) @(negedge clk);
    #0.5;
    checks++;
    if (mod_en !== '0 || mod_src !== '0) begin
      fails++;
      $display("FAIL R1 reset: actual en=%h src=%h expected 0", mod_en, mod_src);
    end
    @(negedge clk);
    rst = 1'b0;

    // R3/R4: base mode, pairing bits ignored
    cur_req = "R4";
    apply(18'h00000 | (18'h1 << 1), 6'h3F, 1'b0);
    chk("R3", 0, 0, 0);
    chk("R3", 3, 1, 0);
    chk("R3", 4, 0, 0);
    chk("R4", 6, 0, 0);
    chk("R4", 9, 1, 6);
    chk("R4", 21, 1, 18);
    chk("R11", 15, 1, 12);

    // R6: selector 0 on pair 0
    cur_req = "R6";
    apply(18'h0, 6'h01, 1'b1);
    chk("R5", 0, 0, 0);
    chk("R6", 3, 1, 0);
    chk("R6", 6, 1, 3);
    chk("R6", 9, 1, 6);
    chk("R4", 10, 1, 7);

    // R7: selector 1 (upper bit set)
    cur_req = "R7";
    apply(18'h1 << 3, 6'h01, 1'b1);
    chk("R7", 3, 1, 0);
    chk("R7", 6, 0, 0);
    chk("R7", 9, 1, 6);

    // R8: selector 2 (lower bit set)
    cur_req = "R8";
    apply(18'h1 << 0, 6'h01, 1'b1);
    chk("R8", 3, 0, 0);
    chk("R8", 6, 1, 3);
    chk("R8", 9, 1, 6);

    // R9 and R10: selector 3
    cur_req = "R9";
    apply((18'h1 << 0) | (18'h1 << 3), 6'h01, 1'b1);
    chk("R9", 3, 0, 0);
    chk("R9", 6, 1, 3);
    chk("R9", 9, 0, 0);
    chk("R10", 3, 0, 0);

    // R4: second-bank pair (bit 3 merges channels 9 and 12)
    cur_req = "R4";
    apply(18'h0, 6'h08, 1'b1);
    chk("R4", 21, 1, 18);
    chk("R4", 24, 1, 21);
    chk("R4", 27, 1, 24);
    chk("R4", 3, 1, 0);
    chk("R4", 6, 0, 0);

    // R11: lone channels ignore pairing
    cur_req = "R11";
    apply(18'h1 << 16, 6'h3F, 1'b1);
    chk("R11", 15, 1, 12);
    chk("R11", 34, 0, 0);
    chk("R11", 33, 1, 30);

    // R12: clearing a pairing bit restores two-operator routing
    cur_req = "R12";
    apply(18'h1 << 0, 6'h01, 1'b1);
    apply(18'h1 << 0, 6'h00, 1'b1);
    chk("R12", 3, 0, 0);
    chk("R12", 6, 0, 0);
    chk("R12", 9, 1, 6);

    // R2: outputs hold with stable inputs, and lag new inputs by one edge
    cur_req = "R2";
    apply(18'h2AAAA, 6'h15, 1'b1);
    held_en = mod_en;
    held_src = mod_src;
    repeat (3) @(negedge clk);
    checks++;
    if (mod_en !== held_en || mod_src !== held_src) begin
      fails++;
      $display("FAIL R2 hold: actual en=%h expected en=%h", mod_en, held_en);
    end
    chan_alg = 18'h15555;
    conn_sel = 6'h2A;
    #1;
    checks++;
    if (mod_en !== held_en || mod_src !== held_src) begin
      fails++;
      $display("FAIL R2 latency: actual en=%h expected en=%h", mod_en, held_en);
    end

    // Random sweep checked by the per-clock model
    cur_req = "R5";
    lf = 32'hACE1_2468;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      chan_alg = lf[17:0];
      conn_sel = lf[23:18];
      ext_mode = lf[24] | lf[25];
      if (i % 50 == 49) rst = 1'b1;
      else rst = 1'b0;
    end
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule